// File: doc/BRIEF.md
# Joystick Axis Timing Counter

This block converts four analog joystick positions into numbers by timing pulses. Each axis drives a one-shot whose pulse width tracks the joystick resistance. Software writes the axis-value port to start a round. The block then pulses a fire output to start all one-shots, and counts prescaled clock ticks on every enabled axis while that axis's one-shot output stays high. The one-shot outputs reach the block as synchronous digital inputs.

When every enabled axis has finished, the block copies the live counts into an output latch, sets a ready flag and, if enabled, raises an interrupt. Software picks one of the four latched counts with a select field and reads it from the axis-value port; that read also clears the interrupt. In continuous mode a new round starts by itself after each completion, so the latch and the interrupt refresh on every round. A slower count rate can be chosen for long pulses.

The controller has four states. IDLE waits for a trigger. FIRE lasts one cycle: it pulses the one-shots and clears the enabled counters and the prescaler. MEASURE counts until all enabled axes are finished. DONE lasts one cycle and loads the latch. The transitions are:
- IDLE to FIRE on a trigger.
- FIRE to MEASURE.
- MEASURE to DONE when all enabled axes are finished.
- DONE to FIRE when continuous mode is set, otherwise DONE to IDLE.
- From any state, a trigger goes to FIRE.

Top module: `gameport_axis_timer`

## Requirements
- R1: After reset, every register reads zero, every latched count reads zero, and irq is low.
- R2: Address 0 is the config register. Bits [3:0] enable axes 1 to 4, bits [5:4] select the axis to read, and bit 6 sets continuous mode. These bits read back as written. Bit 7 reads the ready flag and ignores writes. Address 2 is the hardware config register. Bit 0 enables the interrupt and bits [2:1] set the rate. Bits [15:3] of address 2 read zero. Address 3 reads zero.
- R3: Any write to address 1 starts a round. Ready reads 0 from the next cycle. oneshot_fire is high for exactly the one cycle that follows the write edge. The counters of enabled axes restart from zero.
- R4: An enabled axis adds one to its count on each prescaled tick while its input is high. The first tick of a round comes D clock edges into MEASURE, and later ticks come every D edges, where D is set by the rate code: 00 gives D=1, 10 gives D=2, 01 gives D=20, 11 gives D=200. An axis held high for H MEASURE edges therefore reads floor(H/D).
- R5: A count stops at 0xFFFF. Reaching 0xFFFF finishes that axis even if its input is still high.
- R6: A disabled axis neither counts nor is cleared. It does not hold back completion, and its latched value stays at its previous value.
- R7: When all enabled axes have finished, ready is set. irq is set if bit 0 of the hardware config register is 1. A read strobe at address 1 clears irq.
- R8: A read at address 1 returns the latched count of the axis chosen by config bits [5:4]: 00 is axis 1, 01 is axis 2, 10 is axis 3, 11 is axis 4.
- R9: With config bit 6 clear, no further fire pulse occurs and the latched counts stay frozen until the next write to address 1.
- R10: With config bit 6 set, a new round fires after each completion. Each round reloads the latch and sets irq again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address: 0 config, 1 axis value, 2 hardware config |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; at address 1 it clears irq |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| axis_in | input | 4 | One-shot outputs, one per axis, high while the pulse is active |
| oneshot_fire | output | 1 | One-cycle pulse that starts the one-shots |
| irq | output | 1 | Measurement-complete interrupt |

## Verification
The assertions take the axis inputs to be already synchronous to clk, so a level seen at an edge is the level that was counted. They also take a write to address 1 to be the only way to restart a round. The bench changes axis_in and the register strobes only on the falling clock edge. Its one-shot model starts a pulse only when it sees oneshot_fire, and it ends each pulse after a programmed number of cycles. Every count a check expects therefore follows from R4 with no ambiguity at the edges.

// File: rtl/gp_axis_pkg.sv
package gp_axis_pkg;
    localparam int NUM_AXES = 4;
    localparam int CNT_W    = 16;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FIRE    = 2'd1,
        ST_MEASURE = 2'd2,
        ST_DONE    = 2'd3
    } gp_state_t;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_AXIS = 2'd1;
    localparam logic [1:0] ADDR_HW   = 2'd2;

    // rate codes; the order is not monotonic
    localparam logic [1:0] RATE_FULL      = 2'b00;
    localparam logic [1:0] RATE_HALF      = 2'b10;
    localparam logic [1:0] RATE_TWENTIETH = 2'b01;
    localparam logic [1:0] RATE_SLOWEST   = 2'b11;
endpackage

// File: rtl/gp_tick_gen.sv
module gp_tick_gen
    import gp_axis_pkg::*;
#(
    parameter int DIV_HALF      = 2,
    parameter int DIV_TWENTIETH = 20,
    parameter int DIV_SLOWEST   = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    localparam int PW = $clog2(DIV_SLOWEST + 1);

    logic [PW-1:0] div;
    logic [PW-1:0] pcnt;
    logic          wrap;

    always_comb begin
        unique case (rate)
            RATE_FULL:      div = PW'(1);
            RATE_HALF:      div = PW'(DIV_HALF);
            RATE_TWENTIETH: div = PW'(DIV_TWENTIETH);
            default:        div = PW'(DIV_SLOWEST);
        endcase
    end

    assign wrap = (pcnt == div - PW'(1));
    assign tick = run && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr) begin
            pcnt <= '0;
        end else if (run) begin
            pcnt <= wrap ? '0 : pcnt + PW'(1);
        end
    end
endmodule

// File: rtl/gp_axis_counter.sv
module gp_axis_counter
    import gp_axis_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    input  logic         axis_in,
    output logic [W-1:0] count,
    output logic         done
);
    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            done  <= 1'b1;
        end else if (clr) begin
            done <= !en;
            if (en) count <= '0;
        end else if (run && en && !done) begin
            if (!axis_in) begin
                done <= 1'b1;
            end else if (tick) begin
                count <= count + 1'b1;
                if (count == MAXV - 1'b1) done <= 1'b1;
            end
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == MAXV && !(clr && en)) |=> (count == MAXV));

    assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> $stable(count));
endmodule

// File: rtl/gp_ctrl_fsm.sv
module gp_ctrl_fsm
    import gp_axis_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic all_done,
    input  logic cont_en,
    output logic fire,
    output logic clr,
    output logic run,
    output logic load
);
    gp_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    state_nx = trigger ? ST_FIRE : ST_IDLE;
            ST_FIRE:    state_nx = trigger ? ST_FIRE : ST_MEASURE;
            ST_MEASURE: state_nx = trigger ? ST_FIRE : (all_done ? ST_DONE : ST_MEASURE);
            ST_DONE:    state_nx = (trigger || cont_en) ? ST_FIRE : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        fire = 1'b0;
        clr  = 1'b0;
        run  = 1'b0;
        load = 1'b0;
        unique case (state)
            ST_IDLE:    ;
            ST_FIRE:    begin fire = 1'b1; clr = 1'b1; end
            ST_MEASURE: run  = 1'b1;
            ST_DONE:    load = !trigger;
        endcase
    end

    assert_fire_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !trigger) |=> !fire);
endmodule

// File: rtl/gameport_axis_timer.sv
module gameport_axis_timer
    import gp_axis_pkg::*;
#(
    parameter int DIV_HALF      = 2,
    parameter int DIV_TWENTIETH = 20,
    parameter int DIV_SLOWEST   = 200
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_addr,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [7:0]  reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic [3:0]  axis_in,
    output logic        oneshot_fire,
    output logic        irq
);
    logic [3:0] cfg_en;
    logic [1:0] cfg_sel;
    logic       cfg_cont;
    logic       ready;
    logic       hw_irq_en;
    logic [1:0] hw_rate;

    logic trigger, fsm_clr, fsm_run, fsm_load, tick, all_done;
    logic [NUM_AXES-1:0] axis_done;
    logic [CNT_W-1:0]    live_cnt [NUM_AXES];
    logic [CNT_W-1:0]    held_cnt [NUM_AXES];
    logic                unused_wdata_bit;

    assign unused_wdata_bit = reg_wdata[7];
    assign trigger  = reg_wr && (reg_addr == ADDR_AXIS);
    assign all_done = &axis_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en    <= '0;
            cfg_sel   <= '0;
            cfg_cont  <= 1'b0;
            hw_irq_en <= 1'b0;
            hw_rate   <= RATE_FULL;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_CFG) begin
                cfg_en   <= reg_wdata[3:0];
                cfg_sel  <= reg_wdata[5:4];
                cfg_cont <= reg_wdata[6];
            end
            if (reg_addr == ADDR_HW) begin
                hw_irq_en <= reg_wdata[0];
                hw_rate   <= reg_wdata[2:1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ready <= 1'b0;
        else if (trigger)  ready <= 1'b0;
        else if (fsm_load) ready <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               irq <= 1'b0;
        else if (fsm_load && hw_irq_en)           irq <= 1'b1;
        else if (reg_rd && reg_addr == ADDR_AXIS) irq <= 1'b0;
    end

    gp_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trigger  (trigger),
        .all_done (all_done),
        .cont_en  (cfg_cont),
        .fire     (oneshot_fire),
        .clr      (fsm_clr),
        .run      (fsm_run),
        .load     (fsm_load)
    );

    gp_tick_gen #(
        .DIV_HALF      (DIV_HALF),
        .DIV_TWENTIETH (DIV_TWENTIETH),
        .DIV_SLOWEST   (DIV_SLOWEST)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fsm_clr),
        .run   (fsm_run),
        .rate  (hw_rate),
        .tick  (tick)
    );

    for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
        gp_axis_counter #(.W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (cfg_en[g]),
            .clr     (fsm_clr),
            .run     (fsm_run),
            .tick    (tick),
            .axis_in (axis_in[g]),
            .count   (live_cnt[g]),
            .done    (axis_done[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        held_cnt[g] <= '0;
            else if (fsm_load) held_cnt[g] <= live_cnt[g];
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CFG:  reg_rdata = {8'h00, ready, cfg_cont, cfg_sel, cfg_en};
            ADDR_AXIS: reg_rdata = held_cnt[cfg_sel];
            ADDR_HW:   reg_rdata = {13'd0, hw_rate, hw_irq_en};
            default:   reg_rdata = 16'h0000;
        endcase
    end

    assert_ready_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> !ready);

    assert_irq_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hw_irq_en));
endmodule

// File: tb/sim_gameport_axis_timer.sv
module sim_gameport_axis_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [15:0] reg_rdata;
    logic [3:0]  axis_in = 4'b0000;
    logic        oneshot_fire;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int fire_cnt = 0;
    int hold [4] = '{0, 0, 0, 0};
    int rem  [4] = '{0, 0, 0, 0};
    bit finished = 0;

    string       tag_q [$];
    logic [15:0] exp_q [$];
    logic [15:0] got_q [$];

    always #10 clk = ~clk;

    gameport_axis_timer u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .axis_in(axis_in), .oneshot_fire(oneshot_fire), .irq(irq)
    );

    // one-shot model: pulse is high for hold[i] edges after the FIRE edge
    always @(negedge clk) begin
        if (oneshot_fire) begin
            fire_cnt++;
            for (int i = 0; i < 4; i++) begin
                rem[i] = hold[i] + 1;
                axis_in[i] = 1'b1;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (rem[i] > 0) begin
                    rem[i]--;
                    if (rem[i] == 0) axis_in[i] = 1'b0;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            wait (got_q.size() != 0);
            chk(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_read(input string tag, input logic [1:0] a, input logic [15:0] e);
        tag_q.push_back(tag);
        exp_q.push_back(e);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2 got_q.push_back(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        reg_addr = 2'd0;
        @(negedge clk);
        while (reg_rdata[7] !== 1'b1 && n < 100000) begin
            @(negedge clk);
            n++;
        end
        chk(tag, {15'd0, reg_rdata[7]}, 16'd1);
    endtask

    task automatic set_holds(input int h0, input int h1, input int h2, input int h3);
        hold[0] = h0; hold[1] = h1; hold[2] = h2; hold[3] = h3;
    endtask

    task automatic read_all(input string tag, input logic [1:0] mode,
                            input int e0, input int e1, input int e2, input int e3);
        int ev [4];
        ev[0] = e0; ev[1] = e1; ev[2] = e2; ev[3] = e3;
        for (int s = 0; s < 4; s++) begin
            bus_write(2'd0, {1'b0, mode[0], 2'(s), 4'hF});
            expect_read(tag, 2'd1, 16'(ev[s]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_read("R1 cfg", 2'd0, 16'h0000);
        expect_read("R1 axis", 2'd1, 16'h0000);
        expect_read("R1 hw", 2'd2, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);

        // R2 register fields
        bus_write(2'd0, 8'hFF);
        expect_read("R2 cfg bit7 ignored", 2'd0, 16'h007F);
        bus_write(2'd2, 8'hFF);
        expect_read("R2 hw upper zero", 2'd2, 16'h0007);
        expect_read("R2 addr3 zero", 2'd3, 16'h0000);

        // R3/R4/R7/R8 full rate, all axes
        bus_write(2'd0, 8'h0F);
        bus_write(2'd2, 8'h01);
        set_holds(10, 25, 40, 3);
        bus_write(2'd1, 8'h00);
        chk("R3 fire high", {15'd0, oneshot_fire}, 16'd1);
        expect_read("R3 ready cleared", 2'd0, 16'h000F);
        chk("R3 fire one cycle", {15'd0, oneshot_fire}, 16'd0);
        wait_ready("R7 ready full");
        chk("R7 irq set", {15'd0, irq}, 16'd1);
        read_all("R8 R4 full rate", 2'b00, 10, 25, 40, 3);
        chk("R7 irq cleared by read", {15'd0, irq}, 16'd0);

        // R4 half rate (code 10)
        bus_write(2'd2, 8'h05);
        set_holds(7, 20, 41, 200);
        bus_write(2'd1, 8'h00);
        wait_ready("R4 ready half");
        read_all("R4 half", 2'b00, 3, 10, 20, 100);

        // R4 one twentieth (code 01)
        bus_write(2'd2, 8'h03);
        set_holds(45, 19, 200, 401);
        bus_write(2'd1, 8'h00);
        wait_ready("R4 ready twentieth");
        read_all("R4 twentieth", 2'b00, 2, 0, 10, 20);

        // R4 one two-hundredth (code 11)
        bus_write(2'd2, 8'h07);
        set_holds(450, 199, 1000, 200);
        bus_write(2'd1, 8'h00);
        wait_ready("R4 ready slowest");
        read_all("R4 slowest", 2'b00, 2, 0, 5, 1);

        // R6 disabled axes 2 and 4 (cfg bits 1 and 3 clear)
        bus_write(2'd2, 8'h01);
        bus_write(2'd0, 8'h05);
        set_holds(30, 5000, 60, 5000);
        bus_write(2'd1, 8'h00);
        wait_ready("R6 ready without disabled");
        chk("R6 disabled input still high", {15'd0, axis_in[1]}, 16'd1);
        bus_write(2'd0, 8'h15);
        expect_read("R6 axis2 unchanged", 2'd1, 16'd0);
        bus_write(2'd0, 8'h35);
        expect_read("R6 axis4 unchanged", 2'd1, 16'd1);
        bus_write(2'd0, 8'h05);
        expect_read("R6 axis1 counted", 2'd1, 16'd30);

        // R9 one-shot freeze
        f0 = fire_cnt;
        set_holds(3, 3, 3, 3);
        repeat (300) @(negedge clk);
        chk("R9 no refire", 16'(fire_cnt - f0), 16'd0);
        expect_read("R9 frozen", 2'd1, 16'd30);

        // R10 continuous rounds
        bus_write(2'd0, 8'h4F);
        set_holds(5, 6, 7, 8);
        f0 = fire_cnt;
        bus_write(2'd1, 8'h00);
        repeat (60) @(negedge clk);
        chk("R10 several rounds", {15'd0, (fire_cnt - f0) >= 3}, 16'd1);
        hold[0] = 12;
        repeat (60) @(negedge clk);
        expect_read("R10 relatched", 2'd1, 16'd12);
        chk("R10 irq cleared", {15'd0, irq}, 16'd0);
        repeat (40) @(negedge clk);
        chk("R10 irq again", {15'd0, irq}, 16'd1);
        bus_write(2'd0, 8'h0F);
        repeat (40) @(negedge clk);
        f0 = fire_cnt;
        repeat (100) @(negedge clk);
        chk("R9 stops after clear", 16'(fire_cnt - f0), 16'd0);

        // R5 saturation
        bus_write(2'd0, 8'h01);
        set_holds(70000, 0, 0, 0);
        bus_write(2'd1, 8'h00);
        wait_ready("R5 ready on saturation");
        chk("R5 input still high", {15'd0, axis_in[0]}, 16'd1);
        expect_read("R5 saturated", 2'd1, 16'hFFFF);

        wait (got_q.size() == 0);
        #1;
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule